// File: doc/BRIEF.md
# Receive FIFO Auto Flow-Control Hysteresis

This block drives the active-low flow-control pin (RTS or DTR) of a UART receiver from the fill count of its receive FIFO. It takes the table select, the receive trigger select and the hysteresis code from the configuration, and derives two thresholds from them. The stop threshold is the level at which the far end is told to pause. The restart threshold is the level at which it is allowed to send again. The pin then acts as a latch with hysteresis between the two levels.

Tables A, B and C use fixed trigger levels. For these tables the thresholds are the trigger levels next to the chosen one, above and below. Table D uses the same neighbour rule when its hysteresis code is zero. With a nonzero code, table D places both thresholds a programmable distance from the trigger, clamped to the FIFO range. When automatic flow control is off, the pin follows a software request bit.

Top module: `rx_flow_hyst`

## Requirements
- R1: `tbl_sel` values 0, 1, 2 and 3 select tables A, B, C and D. `trig_sel` values 0 to 3 pick that table's levels in ascending order: A = 1, 4, 8, 14; B = 8, 16, 24, 28; C = 8, 16, 56, 60; D = 8, 16, 32, 56.
- R2: For tables A, B and C, `deassert_lvl` is the next level above the trigger and `reassert_lvl` is the next level below it. The level above the highest entry is the FIFO depth (64), and the level below the lowest entry is 0.
- R3: With table C and a trigger of 56 bytes, `deassert_lvl` is 60 and `reassert_lvl` is 16.
- R4: For table D with `hyst_code` 0, the thresholds follow the neighbour rule of R2.
- R5: For table D with a nonzero `hyst_code` N, `deassert_lvl` is trigger + 4N, limited to 64, and `reassert_lvl` is trigger − 4N, limited to 0.
- R6: With `auto_en` high, `rts_n` is 1 one cycle after a cycle in which `fifo_count` ≥ `deassert_lvl`.
- R7: With `auto_en` high, `rts_n` is 0 one cycle after a cycle in which `fifo_count` ≤ `reassert_lvl` and `fifo_count` < `deassert_lvl`.
- R8: With `auto_en` high, `rts_n` keeps its value while `fifo_count` lies strictly between the two thresholds.
- R9: With `auto_en` low, `rts_n` equals the inverse of `sw_rts` one cycle later, whatever the FIFO count.
- R10: The threshold outputs are registered and follow a configuration change one cycle later. During and right after reset, `rts_n` is 1 and both thresholds are 0.
- R11: Once the thresholds are valid, `deassert_lvl` is always greater than `reassert_lvl` and never above 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | 7 | Receive FIFO fill count, 0 to 64 |
| tbl_sel | input | 2 | Trigger table select (A to D) |
| trig_sel | input | 2 | Receive trigger level select |
| hyst_code | input | 4 | Hysteresis code (table D only) |
| auto_en | input | 1 | Automatic flow control enable |
| sw_rts | input | 1 | Software request bit, 1 asserts the pin (drives it low) |
| rts_n | output | 1 | Flow-control pin, active low |
| deassert_lvl | output | 7 | Current stop threshold |
| reassert_lvl | output | 7 | Current restart threshold |

## Verification
The hardest case to reach is the hold band. The pin shows only its latched state, so the bench must approach a threshold from the correct side and then move back into the band to prove that nothing changes there. For each configuration, the stimulus ramps the count from 0 up to 64 and then back down to 0, one step per cycle. This crosses the stop threshold on the way up and the restart threshold on the way down, and the band is traversed in both directions. The bench records the exact count at which each edge of the pin appears. It does this for every table, every trigger and all sixteen table-D codes, which covers both clamps.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

  typedef enum logic [1:0] {
    TBL_A = 2'd0,
    TBL_B = 2'd1,
    TBL_C = 2'd2,
    TBL_D = 2'd3
  } rxfc_tbl_e;

  localparam int unsigned LEVELS_PER_TBL = 4;

  // Trigger level for a table and an ascending index
  function automatic int unsigned trig_level(input logic [1:0] tbl, input int unsigned idx);
    int unsigned lv;
    lv = 0;
    case (tbl)
      TBL_A: case (idx) 0: lv = 1;  1: lv = 4;  2: lv = 8;  default: lv = 14; endcase
      TBL_B: case (idx) 0: lv = 8;  1: lv = 16; 2: lv = 24; default: lv = 28; endcase
      TBL_C: case (idx) 0: lv = 8;  1: lv = 16; 2: lv = 56; default: lv = 60; endcase
      default: case (idx) 0: lv = 8;  1: lv = 16; 2: lv = 32; default: lv = 56; endcase
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/rxfc_trig_lookup.sv
module rxfc_trig_lookup #(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic [1:0]       tbl_sel,
  input  logic [1:0]       trig_sel,
  output logic [CNT_W-1:0] trig_lvl,
  output logic [CNT_W-1:0] above_lvl,
  output logic [CNT_W-1:0] below_lvl
);
  localparam int unsigned NLV = rxfc_pkg::LEVELS_PER_TBL;

  logic [CNT_W-1:0] lv [NLV];

  for (genvar i = 0; i < NLV; i++) begin : g_lv
    assign lv[i] = CNT_W'(rxfc_pkg::trig_level(tbl_sel, i));
  end

  always_comb begin
    trig_lvl  = lv[trig_sel];
    above_lvl = (trig_sel == 2'(NLV - 1)) ? CNT_W'(FIFO_DEPTH) : lv[trig_sel + 2'd1];
    below_lvl = (trig_sel == 2'd0) ? '0 : lv[trig_sel - 2'd1];
  end
endmodule

// File: rtl/rxfc_thresh_sel.sv
module rxfc_thresh_sel #(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1),
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned HYST_STEP  = 4
) (
  input  logic [1:0]        tbl_sel,
  input  logic [CODE_W-1:0] hyst_code,
  input  logic [CNT_W-1:0]  trig_lvl,
  input  logic [CNT_W-1:0]  above_lvl,
  input  logic [CNT_W-1:0]  below_lvl,
  output logic [CNT_W-1:0]  deas_lvl,
  output logic [CNT_W-1:0]  reas_lvl
);
  localparam int unsigned SW = CNT_W + CODE_W + 8;

  logic [SW-1:0] span, up, trig_w;
  logic          use_hyst;

  always_comb begin
    use_hyst = (tbl_sel == rxfc_pkg::TBL_D) && (hyst_code != '0);
    trig_w   = SW'(trig_lvl);
    span     = SW'(hyst_code) * SW'(HYST_STEP);
    up       = trig_w + span;
    if (use_hyst) begin
      deas_lvl = (up > SW'(FIFO_DEPTH)) ? CNT_W'(FIFO_DEPTH) : up[CNT_W-1:0];
      reas_lvl = (trig_w > span) ? CNT_W'(trig_w - span) : '0;
    end else begin
      deas_lvl = above_lvl;
      reas_lvl = below_lvl;
    end
  end
endmodule

// File: rtl/rxfc_pin_ctl.sv
module rxfc_pin_ctl #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] deas_lvl,
  input  logic [CNT_W-1:0] reas_lvl,
  input  logic             auto_en,
  input  logic             sw_rts,
  output logic             rts_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rts_n <= 1'b1;
    end else if (!auto_en) begin
      rts_n <= ~sw_rts;
    end else if (fifo_count >= deas_lvl) begin
      rts_n <= 1'b1;
    end else if (fifo_count <= reas_lvl) begin
      rts_n <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_flow_hyst.sv
module rx_flow_hyst #(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CODE_W     = 4,
  parameter int unsigned HYST_STEP  = 4,
  parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic [1:0]        tbl_sel,
  input  logic [1:0]        trig_sel,
  input  logic [CODE_W-1:0] hyst_code,
  input  logic              auto_en,
  input  logic              sw_rts,
  output logic              rts_n,
  output logic [CNT_W-1:0]  deassert_lvl,
  output logic [CNT_W-1:0]  reassert_lvl
);
  logic [CNT_W-1:0] trig_lvl, above_lvl, below_lvl;
  logic [CNT_W-1:0] deas_nxt, reas_nxt;

  rxfc_trig_lookup #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_lookup (
    .tbl_sel  (tbl_sel),
    .trig_sel (trig_sel),
    .trig_lvl (trig_lvl),
    .above_lvl(above_lvl),
    .below_lvl(below_lvl)
  );

  rxfc_thresh_sel #(
    .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .CODE_W(CODE_W), .HYST_STEP(HYST_STEP)
  ) u_thresh (
    .tbl_sel  (tbl_sel),
    .hyst_code(hyst_code),
    .trig_lvl (trig_lvl),
    .above_lvl(above_lvl),
    .below_lvl(below_lvl),
    .deas_lvl (deas_nxt),
    .reas_lvl (reas_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      deassert_lvl <= '0;
      reassert_lvl <= '0;
    end else begin
      deassert_lvl <= deas_nxt;
      reassert_lvl <= reas_nxt;
    end
  end

  rxfc_pin_ctl #(.CNT_W(CNT_W)) u_pin (
    .clk       (clk),
    .rst       (rst),
    .fifo_count(fifo_count),
    .deas_lvl  (deassert_lvl),
    .reas_lvl  (reassert_lvl),
    .auto_en   (auto_en),
    .sw_rts    (sw_rts),
    .rts_n     (rts_n)
  );
endmodule

// File: rtl/rxfc_checker.sv
module rxfc_checker #(
  parameter int unsigned FIFO_DEPTH = 64,
  parameter int unsigned CNT_W      = 7
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] fifo_count,
  input logic             auto_en,
  input logic             sw_rts,
  input logic             rts_n,
  input logic [CNT_W-1:0] deassert_lvl,
  input logic [CNT_W-1:0] reassert_lvl
);
  AST_ORDER_VALID: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (deassert_lvl > reassert_lvl)); // R11

  AST_DEAS_CLAMP: assert property (@(posedge clk) disable iff (rst)
    deassert_lvl <= CNT_W'(FIFO_DEPTH)); // R5

  AST_STOP_AT_DEAS: assert property (@(posedge clk) disable iff (rst)
    (auto_en && fifo_count >= deassert_lvl) |=> rts_n); // R6

  AST_GO_AT_REAS: assert property (@(posedge clk) disable iff (rst)
    (auto_en && fifo_count <= reassert_lvl && fifo_count < deassert_lvl) |=> !rts_n); // R7

  AST_HOLD_BAND: assert property (@(posedge clk) disable iff (rst)
    (auto_en && fifo_count > reassert_lvl && fifo_count < deassert_lvl) |=> $stable(rts_n)); // R8

  AST_MANUAL_PIN: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> (rts_n == !$past(sw_rts))); // R9
endmodule

bind rx_flow_hyst rxfc_checker #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fifo_count  (fifo_count),
  .auto_en     (auto_en),
  .sw_rts      (sw_rts),
  .rts_n       (rts_n),
  .deassert_lvl(deassert_lvl),
  .reassert_lvl(reassert_lvl)
);

// File: tb/rx_flow_hyst_test.sv
module rx_flow_hyst_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] fifo_count = '0;
  logic [1:0] tbl_sel = '0;
  logic [1:0] trig_sel = '0;
  logic [3:0] hyst_code = '0;
  logic       auto_en = 1'b0;
  logic       sw_rts = 1'b0;
  logic       rts_n;
  logic [6:0] deassert_lvl, reassert_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_flow_hyst uut (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .tbl_sel(tbl_sel),
    .trig_sel(trig_sel), .hyst_code(hyst_code), .auto_en(auto_en),
    .sw_rts(sw_rts), .rts_n(rts_n), .deassert_lvl(deassert_lvl),
    .reassert_lvl(reassert_lvl)
  );

  function automatic int lvl(input int t, input int i);
    int a [4][4] = '{'{1, 4, 8, 14}, '{8, 16, 24, 28}, '{8, 16, 56, 60}, '{8, 16, 32, 56}};
    return a[t][i];
  endfunction

  function automatic int exp_deas(input int t, input int i, input int n);
    int v;
    if (t == 3 && n != 0) begin
      v = lvl(t, i) + 4 * n;
      return (v > 64) ? 64 : v;
    end
    return (i == 3) ? 64 : lvl(t, i + 1);
  endfunction

  function automatic int exp_reas(input int t, input int i, input int n);
    int v;
    if (t == 3 && n != 0) begin
      v = lvl(t, i) - 4 * n;
      return (v < 0) ? 0 : v;
    end
    return (i == 0) ? 0 : lvl(t, i - 1);
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (tbl=%0d trig=%0d code=%0d cnt=%0d)",
               req, act, expv, tbl_sel, trig_sel, hyst_code, fifo_count);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset rts_n", int'(rts_n), 1);
    chk("R10 reset deassert", int'(deassert_lvl), 0);
    chk("R10 reset reassert", int'(reassert_lvl), 0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_sweep(input int t, input int i, input int n);
    int d, r, st, first_hi, first_lo;
    string tag;
    tag = (t == 3) ? ((n != 0) ? "R5" : "R4") : "R2";
    auto_en = 1'b1;
    fifo_count = '0;
    tbl_sel = 2'(t);
    trig_sel = 2'(i);
    hyst_code = 4'(n);
    @(negedge clk);
    chk("R10 thresholds one cycle after config", int'(deassert_lvl), exp_deas(t, i, n));
    @(negedge clk);
    d = exp_deas(t, i, n);
    r = exp_reas(t, i, n);
    chk({tag, " deassert"}, int'(deassert_lvl), d);
    chk({tag, " reassert"}, int'(reassert_lvl), r);
    chk("R11 order", int'(deassert_lvl > reassert_lvl), 1);
    chk("R7 low at empty", int'(rts_n), 0);
    st = 0;
    first_hi = -1;
    first_lo = -1;
    for (int c = 1; c <= 64; c++) begin
      fifo_count = 7'(c);
      @(negedge clk);
      if (c >= d) st = 1;
      else if (c <= r) st = 0;
      if (st == 1 && first_hi < 0) first_hi = c;
      if (int'(rts_n) != st) chk("R8 ramp up pin", int'(rts_n), st);
    end
    chk("R6 first stop count", first_hi, d);
    for (int c = 63; c >= 0; c--) begin
      fifo_count = 7'(c);
      @(negedge clk);
      if (c >= d) st = 1;
      else if (c <= r) st = 0;
      if (st == 0 && first_lo < 0) first_lo = c;
      if (int'(rts_n) != st) chk("R8 ramp down pin", int'(rts_n), st);
    end
    chk("R7 first restart count", first_lo, r);
  endtask

  task automatic t_example_c();
    auto_en = 1'b1;
    tbl_sel = 2'd2;
    trig_sel = 2'd2;
    hyst_code = 4'd9;
    fifo_count = 7'd20;
    repeat (2) @(negedge clk);
    chk("R3 table C 56 deassert", int'(deassert_lvl), 60);
    chk("R3 table C 56 reassert", int'(reassert_lvl), 16);
    chk("R1 table C level two is 56", lvl(2, 2), 56);
  endtask

  task automatic t_manual();
    auto_en = 1'b0;
    fifo_count = 7'd64;
    sw_rts = 1'b1;
    @(negedge clk);
    chk("R9 manual assert at full", int'(rts_n), 0);
    fifo_count = 7'd0;
    sw_rts = 1'b0;
    @(negedge clk);
    chk("R9 manual release at empty", int'(rts_n), 1);
    sw_rts = 1'b1;
    @(negedge clk);
    chk("R9 manual assert at empty", int'(rts_n), 0);
  endtask

  initial begin
    t_reset();
    t_example_c();
    t_manual();
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 4; i++)
        t_sweep(t, i, 0);
    for (int i = 0; i < 4; i++)
      for (int n = 0; n < 16; n++)
        t_sweep(3, i, n);
    t_manual();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule